// File: doc/BRIEF.md
# Timeslot connection admission sequencer

This block drives the admission side of one timeslot in a synchronous cell switch. On a slot-start pulse it shuffles a fresh input-to-output permutation. It then picks a random first input and walks all inputs once in cyclic order. At each input it draws a pseudo-random byte and compares it with a programmed activity threshold, which decides whether that input carries a cell in this slot. Every active input becomes one connection request, made of a source and a destination, offered to an external path evaluator. The evaluator accepts the request and returns the degradation figure of the path it found. Only one request is outstanding at any time.

A request whose returned degradation is above the programmed ceiling counts as blocked. Any other accepted request counts as established. Three saturating counters accumulate, over many slots, the active requests, the blocked ones and the established ones. Software derives the blocking ratio (blocked over active) and the throughput (established per slot) from these counters.

The controller has six states:
- ST_IDLE leaves on slot_start to ST_SHUFFLE, reloading the identity permutation.
- ST_SHUFFLE performs one swap per cycle, from the top index down to index 1, then goes to ST_PICK.
- ST_PICK latches the random start input and goes to ST_SCAN.
- ST_SCAN draws activity for the current input. It goes to ST_ISSUE when the input is active. Otherwise it moves to the next input, or to ST_DONE after the last input.
- ST_ISSUE holds the request until the evaluator accepts it. It then goes to ST_SCAN, or to ST_DONE after the last input.
- ST_DONE pulses slot_done and returns to ST_IDLE.

Top module: `tsa_admit_seq`

## Requirements
- R1: A synchronous active-low reset clears all three counters and returns the controller to idle, with busy and req_valid both low.
- R2: Within one slot, no input is requested twice and no two requests carry the same destination, so the destinations form part of a permutation.
- R3: Within one slot, requests appear in cyclic input order from the start input. The offset (src - first_src) mod N_PORTS strictly increases from one request to the next.
- R4: The start input is drawn pseudo-randomly per slot. Over repeated slots with every input active, more than one start input appears.
- R5: An input is active when the random byte is below cfg_rho, and always when cfg_rho is 8'hFF. With cfg_rho = 0 a slot issues no request. With 8'hFF it issues exactly N_PORTS requests.
- R6: Once req_valid is high, it stays high and req_src and req_dst stay stable until req_ready is high at a clock edge.
- R7: cnt_active increases by exactly one for each accepted request (req_valid and req_ready both high at a clock edge).
- R8: An accepted request with req_deg > cfg_max_deg increments cnt_blocked. One with req_deg <= cfg_max_deg increments cnt_established, so a figure equal to the ceiling counts as established.
- R9: Each counter holds at its all-ones value instead of wrapping.
- R10: Each slot ends with exactly one slot_done pulse. busy is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_start | input | 1 | Begins a slot when the block is idle |
| cfg_rho | input | 8 | Activity threshold; 8'hFF means always active |
| cfg_max_deg | input | DEG_W | Highest degradation still admitted |
| req_valid | output | 1 | Connection request offered |
| req_ready | input | 1 | Evaluator accepts the request this cycle |
| req_src | output | IDX_W | Requested input |
| req_dst | output | IDX_W | Requested output |
| req_deg | input | DEG_W | Degradation of the path, valid with req_ready |
| slot_done | output | 1 | One-cycle pulse at the end of a slot |
| busy | output | 1 | Slot in progress |
| cnt_active | output | CNT_W | Accepted requests, saturating |
| cnt_blocked | output | CNT_W | Blocked requests, saturating |
| cnt_established | output | CNT_W | Established requests, saturating |

## Verification
The bench runs slots with full activity and an always-ready evaluator. These show that each slot is a complete permutation walked in wrap-around order, and that the start input varies from slot to slot. Slots with zero activity separate the threshold path from the walk itself. Slots at half activity, with a stalling evaluator and random degradation figures, exercise request holding and the blocked/established split, including figures equal to the ceiling. A long run at full activity, with narrowed counters, drives them into saturation, and a reset in mid-run shows that they clear.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHUFFLE,
        ST_PICK,
        ST_SCAN,
        ST_ISSUE,
        ST_DONE
    } tsa_state_e;
endpackage

// File: rtl/tsa_lfsr.sv
module tsa_lfsr #(
    parameter int W              = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter int OUT_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] value
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (state_q[0])
            state_q <= {1'b0, state_q[W-1:1]} ^ TAPS;
        else
            state_q <= {1'b0, state_q[W-1:1]};
    end

    assign value = state_q[OUT_W-1:0];
endmodule

// File: rtl/tsa_sat_cnt.sv
module tsa_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (inc && (q != '1))
            q <= q + W'(1);
    end

    // R9: a full counter stays full
    assert_hold_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q == '1) |=> (q == '1));

    // R7: the count never moves by more than one per cycle
    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q != '1) |=> ((q == $past(q)) || (q == $past(q) + W'(1))));
endmodule

// File: rtl/tsa_perm_tbl.sv
module tsa_perm_tbl #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             init,
    input  logic             swap_en,
    input  logic [IDX_W-1:0] swap_a,
    input  logic [IDX_W-1:0] swap_b,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] rd_data
);
    logic [IDX_W-1:0] tbl [N];

    always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
            if (init)
                tbl[k] <= IDX_W'(k);
            else if (swap_en && (swap_a == IDX_W'(k)))
                tbl[k] <= tbl[swap_b];
            else if (swap_en && (swap_b == IDX_W'(k)))
                tbl[k] <= tbl[swap_a];
        end
    end

    assign rd_data = tbl[rd_idx];
endmodule

// File: rtl/tsa_admit_seq.sv
module tsa_admit_seq
    import tsa_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int DEG_W   = 4,
    parameter int CNT_W   = 32,
    parameter int LFSR_W  = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    localparam int IDX_W  = $clog2(N_PORTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_start,
    input  logic [7:0]       cfg_rho,
    input  logic [DEG_W-1:0] cfg_max_deg,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [IDX_W-1:0] req_src,
    output logic [IDX_W-1:0] req_dst,
    input  logic [DEG_W-1:0] req_deg,
    output logic             slot_done,
    output logic             busy,
    output logic [CNT_W-1:0] cnt_active,
    output logic [CNT_W-1:0] cnt_blocked,
    output logic [CNT_W-1:0] cnt_established
);
    localparam int RND_W = 8;
    localparam int PW    = RND_W + IDX_W + 1;

    tsa_state_e state_q, state_d;
    logic [RND_W-1:0] rnd;
    logic [IDX_W-1:0] shuf_i, start_q, step_q, src_q, dst_q, cur, tbl_rd;
    logic [IDX_W:0]   sum;
    logic tbl_init, swap_en, active, last_step, hs, over;

    // maps a random byte onto 0 .. k-1 by scaling
    function automatic logic [IDX_W-1:0] scale(input logic [RND_W-1:0] r,
                                               input logic [IDX_W:0] k);
        logic [PW-1:0] p;
        p = PW'(r) * PW'(k);
        return p[RND_W +: IDX_W];
    endfunction

    tsa_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .OUT_W(RND_W)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .value(rnd));

    tsa_perm_tbl #(.N(N_PORTS), .IDX_W(IDX_W)) i_perm (
        .clk(clk), .init(tbl_init), .swap_en(swap_en),
        .swap_a(shuf_i), .swap_b(scale(rnd, {1'b0, shuf_i} + 1'b1)),
        .rd_idx(cur), .rd_data(tbl_rd));

    assign sum       = {1'b0, start_q} + {1'b0, step_q};
    assign cur       = (sum >= (IDX_W+1)'(N_PORTS)) ? IDX_W'(sum - (IDX_W+1)'(N_PORTS))
                                                   : IDX_W'(sum);
    assign active    = (rnd < cfg_rho) || (cfg_rho == 8'hFF);
    assign last_step = (step_q == IDX_W'(N_PORTS - 1));
    assign hs        = req_valid && req_ready;
    assign over      = req_deg > cfg_max_deg;
    assign req_src   = src_q;
    assign req_dst   = dst_q;
    assign busy      = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        req_valid = 1'b0;
        slot_done = 1'b0;
        tbl_init  = 1'b0;
        swap_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (slot_start) begin
                tbl_init = 1'b1;
                state_d  = ST_SHUFFLE;
            end
            ST_SHUFFLE: begin
                swap_en = 1'b1;
                if (shuf_i == IDX_W'(1)) state_d = ST_PICK;
            end
            ST_PICK: state_d = ST_SCAN;
            ST_SCAN: begin
                if (active)         state_d = ST_ISSUE;
                else if (last_step) state_d = ST_DONE;
            end
            ST_ISSUE: begin
                req_valid = 1'b1;
                if (req_ready) state_d = last_step ? ST_DONE : ST_SCAN;
            end
            ST_DONE: begin
                slot_done = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shuf_i  <= IDX_W'(N_PORTS - 1);
            start_q <= '0;
            step_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
        end else begin
            if (state_q == ST_IDLE)    shuf_i <= IDX_W'(N_PORTS - 1);
            if (state_q == ST_SHUFFLE) shuf_i <= shuf_i - IDX_W'(1);
            if (state_q == ST_PICK) begin
                start_q <= scale(rnd, (IDX_W+1)'(N_PORTS));
                step_q  <= '0;
            end
            if (state_q == ST_SCAN) begin
                if (active) begin
                    src_q <= cur;
                    dst_q <= tbl_rd;
                end else if (!last_step) begin
                    step_q <= step_q + IDX_W'(1);
                end
            end
            if ((state_q == ST_ISSUE) && req_ready && !last_step)
                step_q <= step_q + IDX_W'(1);
        end
    end

    tsa_sat_cnt #(.W(CNT_W)) i_cnt_act (
        .clk(clk), .rst_n(rst_n), .inc(hs), .q(cnt_active));
    tsa_sat_cnt #(.W(CNT_W)) i_cnt_blk (
        .clk(clk), .rst_n(rst_n), .inc(hs && over), .q(cnt_blocked));
    tsa_sat_cnt #(.W(CNT_W)) i_cnt_est (
        .clk(clk), .rst_n(rst_n), .inc(hs && !over), .q(cnt_established));

    // R6: a stalled request is held unchanged
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_src) && $stable(req_dst)));

    // R10: slot_done is followed by idle
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_done |=> !busy);

    // R8: a figure above the ceiling bumps the blocked count
    assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && (req_deg > cfg_max_deg) && (cnt_blocked != '1))
        |=> (cnt_blocked == $past(cnt_blocked) + CNT_W'(1)));

    // R8: a figure at or below the ceiling bumps the established count
    assert_established_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && (req_deg <= cfg_max_deg) && (cnt_established != '1))
        |=> (cnt_established == $past(cnt_established) + CNT_W'(1)));
endmodule

// File: tb/test_tsa_admit_seq.sv
module test_tsa_admit_seq;
    localparam int N     = 8;
    localparam int IW    = 3;
    localparam int DEG_W = 4;
    localparam int CNT_W = 8;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_start = 1'b0;
    logic [7:0] cfg_rho = 8'hFF;
    logic [DEG_W-1:0] cfg_max_deg = 4'd3;
    logic req_valid, req_ready, slot_done, busy;
    logic [IW-1:0] req_src, req_dst;
    logic [DEG_W-1:0] req_deg;
    logic [CNT_W-1:0] cnt_active, cnt_blocked, cnt_established;

    always #10 clk = ~clk;

    tsa_admit_seq #(.N_PORTS(N), .DEG_W(DEG_W), .CNT_W(CNT_W)) i_tsa_admit_seq (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .cfg_rho(cfg_rho),
        .cfg_max_deg(cfg_max_deg), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst), .req_deg(req_deg),
        .slot_done(slot_done), .busy(busy), .cnt_active(cnt_active),
        .cnt_blocked(cnt_blocked), .cnt_established(cnt_established));

    int checks = 0, errors = 0;
    int exp_act = 0, exp_blk = 0, exp_est = 0, eq_hits = 0;
    int slot_src[$], slot_dst[$];
    bit pend = 0, rdy_random = 0, finished = 0;
    logic [IW-1:0] pend_src, pend_dst;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // evaluator model: drives ready and a degradation figure
    always @(negedge clk) begin
        req_ready = rdy_random ? 1'($urandom % 2) : 1'b1;
        req_deg   = DEG_W'($urandom % 8);
    end

    // reference model: updated from the handshakes seen at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_act = 0; exp_blk = 0; exp_est = 0; pend = 0;
        end else begin
            if (req_valid && req_ready) begin
                slot_src.push_back(int'(req_src));
                slot_dst.push_back(int'(req_dst));
                if (exp_act < CMAX) exp_act++;
                if (req_deg > cfg_max_deg) begin
                    if (exp_blk < CMAX) exp_blk++;
                end else begin
                    if (exp_est < CMAX) exp_est++;
                    if (req_deg == cfg_max_deg) eq_hits++;
                end
            end
            pend = req_valid && !req_ready;
            pend_src = req_src;
            pend_dst = req_dst;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(cnt_active) == exp_act, "R7 cnt_active", int'(cnt_active), exp_act);
            chk(int'(cnt_blocked) == exp_blk, "R8 cnt_blocked", int'(cnt_blocked), exp_blk);
            chk(int'(cnt_established) == exp_est, "R8 cnt_established",
                int'(cnt_established), exp_est);
            if (pend)
                chk(req_valid && req_src == pend_src && req_dst == pend_dst,
                    "R6 request hold", int'({req_valid, req_src, req_dst}),
                    int'({1'b1, pend_src, pend_dst}));
        end
    end

    task automatic run_slot(output int nreq);
        @(negedge clk);
        slot_src.delete();
        slot_dst.delete();
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        while (!slot_done) @(negedge clk);
        nreq = slot_src.size();
        // R2: distinct sources and destinations
        for (int a = 0; a < nreq; a++)
            for (int b = a + 1; b < nreq; b++) begin
                chk(slot_src[a] != slot_src[b], "R2 source repeated", slot_src[b], -1);
                chk(slot_dst[a] != slot_dst[b], "R2 destination repeated", slot_dst[b], -1);
            end
        // R3: cyclic order from the first request
        for (int k = 1; k < nreq; k++) begin
            int o1, o0;
            o1 = (slot_src[k] - slot_src[0] + N) % N;
            o0 = (slot_src[k-1] - slot_src[0] + N) % N;
            chk(o1 > o0, "R3 walk order", o1, o0 + 1);
        end
        @(negedge clk);
        chk(!busy, "R10 busy after slot_done", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n, starts;
        bit seen [N];
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cnt_active == 0 && cnt_blocked == 0 && cnt_established == 0,
            "R1 counters at reset", int'(cnt_active), 0);
        chk(!busy && !req_valid, "R1 idle at reset", int'({busy, req_valid}), 0);
        rst_n = 1'b1;

        // full activity, always-ready evaluator
        cfg_rho = 8'hFF;
        rdy_random = 0;
        for (int s = 0; s < 20; s++) begin
            run_slot(n);
            chk(n == N, "R5 full activity count", n, N);
            if (n > 0) seen[slot_src[0]] = 1;
        end
        starts = 0;
        for (int k = 0; k < N; k++) starts += int'(seen[k]);
        chk(starts >= 2, "R4 start inputs seen", starts, 2);

        // zero activity
        cfg_rho = 8'h00;
        for (int s = 0; s < 5; s++) begin
            run_slot(n);
            chk(n == 0, "R5 zero activity count", n, 0);
        end

        // half activity, stalling evaluator
        cfg_rho = 8'h80;
        rdy_random = 1;
        for (int s = 0; s < 40; s++) begin
            run_slot(n);
            chk(n <= N, "R5 partial activity bound", n, N);
        end
        chk(eq_hits > 0, "R8 ceiling-equal figure seen", eq_hits, 1);

        // drive into saturation
        cfg_rho = 8'hFF;
        rdy_random = 0;
        for (int s = 0; s < 40; s++) run_slot(n);
        chk(int'(cnt_active) == CMAX, "R9 saturation", int'(cnt_active), CMAX);

        // reset in mid-run
        @(negedge clk);
        slot_start = 1'b1;
        repeat (4) @(negedge clk);
        slot_start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(cnt_active == 0 && cnt_blocked == 0 && cnt_established == 0,
            "R1 counters cleared", int'(cnt_active), 0);
        chk(!busy && !req_valid, "R1 idle after reset", int'({busy, req_valid}), 0);
        finish_run();
    end
endmodule